// File: doc/BRIEF.md
# Vertical Sync Period Meter

This block measures the spacing of vertical sync pulses in units of an external 8 µs timebase. A free-running interval counter adds one on every timebase strobe. A rising edge on the vertical sync input, after synchronisation, ends the interval. The count reached so far is copied into a result register, and counting starts again from zero.

When sync pulses stop, or arrive too slowly, the interval hits a timeout chosen by a 2-bit select. The block then raises an overflow flag, leaves the last good result untouched, and starts a fresh interval. The flag is rewritten only when an interval finishes. A valid measurement clears it, and another timeout keeps it set.

Every result or flag update comes with a one-cycle done strobe. Mode-detection firmware or a downstream state machine can use that strobe to sample the pair.

Top module: `vsync_period_meter`

## Requirements
- R1: While reset is held low and in the first cycle after it is released, `resultCnt` is 0, `ovfFlag` is 0 and `doneStb` is 0.
- R2: The interval counter advances by one on each cycle with `tickStb` high. `vsyncIn` goes through a two-flop synchroniser. On the third rising clock edge that samples `vsyncIn` high after it was low, `resultCnt` takes the number of ticks since the interval began, and the counter restarts at zero.
- R3: A tick in the same cycle as the detected sync edge is not counted: the latched value excludes it, and the new interval starts at zero.
- R4: Only a low-to-high transition of `vsyncIn` ends an interval. Holding the input high for many cycles produces exactly one measurement.
- R5: With select value s (`timeoutSel`, 2 bits, unsigned), the timeout is (s+1)·2^(CNT_W−2) ticks. A tick that would bring the count to that value is a timeout. At the default width that gives 00→4096, 01→8192, 10→12288 and 11→16384 ticks, which is 32.768, 65.536, 98.304 and 131.072 ms at 8 µs.
- R6: On a timeout, `ovfFlag` becomes 1, `resultCnt` keeps its previous value, and the counter restarts at zero.
- R7: `ovfFlag` changes only when an interval ends. A valid measurement writes 0 and a further timeout writes 1, so the flag stays high across repeated timeouts.
- R8: `doneStb` is high for exactly one cycle per interval end, whether it ended by measurement or by timeout. It is low at all other times, and `resultCnt` changes only in a cycle where `doneStb` is high.
- R9: If `timeoutSel` is lowered while the count already equals or exceeds the new timeout minus one, the next tick is a timeout.
- R10: When the sync edge and a timeout tick fall in the same cycle, the measurement wins. The result becomes timeout−1 and `ovfFlag` becomes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickStb | input | 1 | One-cycle 8 µs timebase strobe |
| vsyncIn | input | 1 | Asynchronous vertical sync level |
| timeoutSel | input | 2 | Timeout length select |
| resultCnt | output | CNT_W (14) | Last measured interval in ticks |
| ovfFlag | output | 1 | Last interval ended by timeout |
| doneStb | output | 1 | One-cycle update strobe |

## Verification
The bench builds the meter with CNT_W = 6. This scales the four timeouts down to 16, 32, 48 and 64 ticks, so every select value can be driven all the way to overflow within a few hundred cycles. At this width the longest timeout equals the full range of the result register. A latched value of 63 therefore exercises the same saturation boundary that 16383 does at the default width. It also lets the collisions of R3 and R10, a tick landing on the sync edge with and without a pending timeout, be placed on exact cycles.

// File: rtl/vpm_pkg.sv
package vpm_pkg;

  // Strobes issued by the control unit to the datapath each cycle.
  typedef struct packed {
    logic restart;  // clear the interval counter
    logic latch;    // copy count into result, clear overflow
    logic expire;   // timeout: set overflow, keep result
  } vpm_strobe_t;

endpackage

// File: rtl/vpm_sync_edge.sv
module vpm_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic riseEvt
);

  logic [STAGES-1:0] syncChain;
  logic              lastLevel;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rstN) syncChain[0] <= 1'b0;
          else       syncChain[0] <= asyncIn;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rstN) syncChain[g] <= 1'b0;
          else       syncChain[g] <= syncChain[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) lastLevel <= 1'b0;
    else       lastLevel <= syncChain[STAGES-1];
  end

  assign riseEvt = syncChain[STAGES-1] & ~lastLevel;

endmodule

// File: rtl/vpm_ctrl.sv
module vpm_ctrl
  import vpm_pkg::*;
#(
  parameter int CNT_W = 14,
  parameter int SEL_W = 2
) (
  input  logic              tickStb,
  input  logic              syncRise,
  input  logic [SEL_W-1:0]  timeoutSel,
  input  logic [CNT_W-1:0]  curCount,
  output vpm_strobe_t       strobes
);

  localparam int SHIFT = CNT_W - SEL_W;
  localparam int LW    = CNT_W + 1;

  logic [LW-1:0] limitTicks;
  logic [LW-1:0] nextCount;
  logic          hitLimit;

  // Timeout length: (sel + 1) steps of 2^SHIFT ticks.
  always_comb begin
    limitTicks = (LW'(timeoutSel) + LW'(1)) << SHIFT;
    nextCount  = LW'(curCount) + LW'(1);
    hitLimit   = (nextCount >= limitTicks);
  end

  // Sync edge has priority over a coincident timeout tick.
  always_comb begin
    strobes.latch   = syncRise;
    strobes.expire  = tickStb & ~syncRise & hitLimit;
    strobes.restart = strobes.latch | strobes.expire;
  end

endmodule

// File: rtl/vpm_datapath.sv
module vpm_datapath
  import vpm_pkg::*;
#(
  parameter int CNT_W = 14
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickStb,
  input  vpm_strobe_t       strobes,
  output logic [CNT_W-1:0]  curCount,
  output logic [CNT_W-1:0]  resultCnt,
  output logic              ovfFlag,
  output logic              doneStb
);

  always_ff @(posedge clk) begin
    if (!rstN)                curCount <= '0;
    else if (strobes.restart) curCount <= '0;
    else if (tickStb)         curCount <= curCount + CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN)              resultCnt <= '0;
    else if (strobes.latch) resultCnt <= curCount;
  end

  always_ff @(posedge clk) begin
    if (!rstN)               ovfFlag <= 1'b0;
    else if (strobes.latch)  ovfFlag <= 1'b0;
    else if (strobes.expire) ovfFlag <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) doneStb <= 1'b0;
    else       doneStb <= strobes.latch | strobes.expire;
  end

endmodule

// File: rtl/vsync_period_meter.sv
module vsync_period_meter
  import vpm_pkg::*;
#(
  parameter int CNT_W       = 14,
  parameter int SEL_W       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickStb,
  input  logic              vsyncIn,
  input  logic [SEL_W-1:0]  timeoutSel,
  output logic [CNT_W-1:0]  resultCnt,
  output logic              ovfFlag,
  output logic              doneStb
);

  logic             syncRise;
  logic [CNT_W-1:0] curCount;
  vpm_strobe_t      strobes;

  vpm_sync_edge #(.STAGES(SYNC_STAGES)) sync_i (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn (vsyncIn),
    .riseEvt (syncRise)
  );

  vpm_ctrl #(.CNT_W(CNT_W), .SEL_W(SEL_W)) ctrl_i (
    .tickStb    (tickStb),
    .syncRise   (syncRise),
    .timeoutSel (timeoutSel),
    .curCount   (curCount),
    .strobes    (strobes)
  );

  vpm_datapath #(.CNT_W(CNT_W)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .tickStb   (tickStb),
    .strobes   (strobes),
    .curCount  (curCount),
    .resultCnt (resultCnt),
    .ovfFlag   (ovfFlag),
    .doneStb   (doneStb)
  );

endmodule

// File: rtl/vpm_checker.sv
module vpm_checker #(
  parameter int CNT_W = 14
) (
  input logic             clk,
  input logic             rstN,
  input logic             tickStb,
  input logic [CNT_W-1:0] resultCnt,
  input logic             ovfFlag,
  input logic             doneStb
);

  // R8
  result_needs_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(resultCnt) |-> doneStb);

  // R7
  ovf_needs_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(ovfFlag) |-> doneStb);

  // R6
  ovf_keeps_result_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ovfFlag) |-> $stable(resultCnt));

  // R5
  ovf_from_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ovfFlag) |-> $past(tickStb));

endmodule

bind vsync_period_meter vpm_checker #(.CNT_W(CNT_W)) vpm_checker_i (
  .clk       (clk),
  .rstN      (rstN),
  .tickStb   (tickStb),
  .resultCnt (resultCnt),
  .ovfFlag   (ovfFlag),
  .doneStb   (doneStb)
);

// File: tb/vsync_period_meter_tb_top.sv
module vsync_period_meter_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 6;
  localparam int STEP       = 1 << (CNT_W - 2);

  typedef struct {
    int    res;
    bit    ovf;
    string tag;
  } exp_t;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             tickStb = 1'b0;
  logic             vsyncIn = 1'b0;
  logic [1:0]       timeoutSel = 2'd3;
  logic [CNT_W-1:0] resultCnt;
  logic             ovfFlag;
  logic             doneStb;

  int   checks = 0;
  int   failures = 0;
  int   tickCount = 0;
  int   expRes = 0;
  exp_t expQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  vsync_period_meter #(.CNT_W(CNT_W)) dut_i (
    .clk        (clk),
    .rstN       (rstN),
    .tickStb    (tickStb),
    .vsyncIn    (vsyncIn),
    .timeoutSel (timeoutSel),
    .resultCnt  (resultCnt),
    .ovfFlag    (ovfFlag),
    .doneStb    (doneStb)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int curLimit();
    return (int'(timeoutSel) + 1) * STEP;
  endfunction

  // Driver: issue n consecutive ticks and predict any timeouts.
  task automatic doTicks(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tickStb = 1'b1;
      if (tickCount >= curLimit() - 1) begin
        expQ.push_back('{expRes, 1'b1, tag});
        tickCount = 0;
      end else begin
        tickCount++;
      end
    end
    @(negedge clk);
    tickStb = 1'b0;
  endtask

  // Driver: sync pulse, optionally with a tick on the edge-detect cycle.
  task automatic syncPulse(input int hold, input bit withTick, input string tag);
    @(negedge clk);
    vsyncIn = 1'b1;
    expQ.push_back('{tickCount, 1'b0, tag});
    expRes    = tickCount;
    tickCount = 0;
    @(negedge clk);
    @(negedge clk);
    if (withTick) tickStb = 1'b1;
    check(doneStb == 1'b0, "R2 latency early", int'(doneStb), 0);
    @(negedge clk);
    tickStb = 1'b0;
    check(doneStb == 1'b1, "R2 latency", int'(doneStb), 1);
    repeat (hold) @(negedge clk);
    vsyncIn = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  // Monitor: compare each update against the scoreboard.
  always @(negedge clk) begin
    if (rstN && doneStb) begin
      if (expQ.size() == 0) begin
        checks++;
        failures++;
        $display("FAIL R8 unexpected done: actual result=%0d ovf=%0b expected=no update",
                 resultCnt, ovfFlag);
      end else begin
        exp_t e;
        e = expQ.pop_front();
        checks++;
        if (int'(resultCnt) != e.res || ovfFlag != e.ovf) begin
          failures++;
          $display("FAIL %s: actual result=%0d ovf=%0b expected result=%0d ovf=%0b",
                   e.tag, resultCnt, ovfFlag, e.res, e.ovf);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL R8 watchdog: actual=hung expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(resultCnt == '0 && ovfFlag == 1'b0 && doneStb == 1'b0, "R1 in reset",
          int'(resultCnt) + int'(ovfFlag) + int'(doneStb), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(resultCnt == '0 && ovfFlag == 1'b0 && doneStb == 1'b0, "R1 after reset",
          int'(resultCnt) + int'(ovfFlag) + int'(doneStb), 0);

    // R2: plain measurements, including zero and the full-range value
    timeoutSel = 2'd3;
    syncPulse(2, 1'b0, "R2 first");
    doTicks(10, "R2");
    syncPulse(2, 1'b0, "R2 ten");
    syncPulse(2, 1'b0, "R2 zero");
    doTicks(63, "R2");
    syncPulse(2, 1'b0, "R2 max");

    // R3: tick coincident with edge is not counted
    doTicks(5, "R3");
    syncPulse(2, 1'b1, "R3 coincident tick");
    doTicks(2, "R3");
    syncPulse(2, 1'b0, "R3 restart zero");

    // R4: long high level gives one measurement
    doTicks(7, "R4");
    syncPulse(40, 1'b0, "R4 long high");
    check(expQ.size() == 0, "R4 single update", expQ.size(), 0);

    // R5/R6/R7: shortest timeout, repeated, then cleared
    timeoutSel = 2'd0;
    syncPulse(2, 1'b0, "R5 prep");
    doTicks(4, "R5");
    syncPulse(2, 1'b0, "R5 base");
    doTicks(16, "R5 R6 sel0 timeout");
    check(ovfFlag == 1'b1 && int'(resultCnt) == 4, "R6 result kept", int'(resultCnt), 4);
    doTicks(16, "R7 repeated timeout");
    check(ovfFlag == 1'b1, "R7 flag held", int'(ovfFlag), 1);
    doTicks(3, "R7");
    syncPulse(2, 1'b0, "R7 cleared by measurement");
    check(ovfFlag == 1'b0, "R7 flag cleared", int'(ovfFlag), 0);

    // R5: remaining select values
    timeoutSel = 2'd1;
    syncPulse(2, 1'b0, "R5 prep");
    doTicks(32, "R5 sel1 timeout");
    timeoutSel = 2'd2;
    doTicks(48, "R5 sel2 timeout");
    timeoutSel = 2'd3;
    doTicks(64, "R5 sel3 timeout");
    doTicks(1, "R6 restart");
    syncPulse(2, 1'b0, "R6 count after restart");

    // R9: select lowered below current count
    timeoutSel = 2'd3;
    syncPulse(2, 1'b0, "R9 prep");
    doTicks(40, "R9");
    timeoutSel = 2'd0;
    doTicks(1, "R9 immediate timeout");
    check(ovfFlag == 1'b1, "R9 flag", int'(ovfFlag), 1);

    // R10: edge and timeout tick in the same cycle
    timeoutSel = 2'd0;
    syncPulse(2, 1'b0, "R10 prep");
    doTicks(15, "R10");
    syncPulse(2, 1'b1, "R10 edge beats timeout");
    check(ovfFlag == 1'b0 && int'(resultCnt) == 15, "R10 result", int'(resultCnt), 15);

    repeat (10) @(negedge clk);
    check(expQ.size() == 0, "R8 all updates seen", expQ.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule